// File: doc/BRIEF.md
# Prefetch Burst Data Converter

This block sits between a memory core that moves one wide word per access and a narrow data pin path that carries one beat on every clock edge. A core word is four pin beats wide. On a read burst the block asks the core for one word per group of four beats and sends the word out one lane per beat. On a write burst it gathers four pin beats and their per-byte mask bits into one core word with a byte-enable vector. While a burst runs it also produces the column address of every beat. The column sequence is set by a burst length and an ordering chosen when the burst is started.

Half-cycle beats are modelled with a clock running at twice the core rate (`clk2x`). One beat takes one `clk2x` cycle. A phase bit marks the two halves of each core cycle. Bursts may only start on a core-cycle boundary, so every group of four beats fills exactly two core cycles.

Top module: `prefetch_burst_conv`

## Requirements
- R1: While `rst_n` is low, `busy_o`, `dq_vld_o`, `wr_vld_o` and `core_ph_o` are all 0.
- R2: A start request is taken at a `clk2x` edge only if `start_i` is 1, `busy_o` is 0, `core_ph_o` is 0 and `blen_i` is not 3. In any other case it is ignored. Once taken, `busy_o` is 1 for exactly BL cycles, and the k-th of those cycles (k = 0..BL-1) is beat cycle k.
- R3: The `blen_i` code is 0 for BL=4, 1 for BL=8 and 2 for BL=16. Code 3 is reserved, and a start request with code 3 does not begin a burst.
- R4: When `ilv_i` was 0 at start, the column of beat k is `col - (col mod BL) + ((col mod BL) + k) mod BL`. The column therefore counts up and wraps inside the block of BL columns that holds the start column.
- R5: When `ilv_i` was 1 at start, the column of beat k is `col XOR k`.
- R6: In a read burst, `rd_req_o` is 1 exactly in the beat cycles with k mod 4 = 0, and `core_ph_o` is 1 in those cycles. `rd_word_i` is sampled in that cycle for the column on `beat_col_o`.
- R7: In a read burst, the beat for cycle k appears on `dq_o` with `dq_vld_o` = 1 in the following cycle. Its value is lane k mod 4, bits [(k mod 4)*16 +: 16], of the word fetched for beat 4*floor(k/4).
- R8: In a write burst, `dq_i` is sampled in beat cycle k and placed in lane k mod 4, bits [(k mod 4)*16 +: 16], of the assembled word. Data in masked bytes passes through unchanged.
- R9: In a write burst, `wr_vld_o` pulses for one cycle in the cycle after beat 4g+3. In that cycle `wr_word_o` holds the four lanes and `wr_col_o` holds the column of beat 4g. `wr_vld_o` is 0 in every other cycle.
- R10: `wr_be_o` bit l*2+b is the inverse of `dm_i` bit b sampled in lane l's beat cycle. A `dm_i` bit of 1 masks byte b (bits [b*8 +: 8]) of that beat.
- R11: After reset is released, `core_ph_o` toggles on every `clk2x` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the core rate; one beat per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a burst |
| wr_i | input | 1 | Direction of the requested burst: 1 write, 0 read |
| blen_i | input | 2 | Burst length code (0:4, 1:8, 2:16, 3 reserved) |
| ilv_i | input | 1 | Ordering: 0 sequential wrap, 1 interleaved |
| col_i | input | COL_W | Start column |
| core_ph_o | output | 1 | Half of the current core cycle (0 first, 1 second) |
| busy_o | output | 1 | Burst in progress |
| beat_col_o | output | COL_W | Column of the current beat |
| rd_req_o | output | 1 | Core word fetch strobe for a read group |
| rd_word_i | input | 4*N_W | Core word returned for `beat_col_o` |
| dq_o | output | N_W | Read beat toward the pins |
| dq_vld_o | output | 1 | `dq_o` carries a valid read beat |
| dq_i | input | N_W | Write beat from the pins |
| dm_i | input | N_W/8 | Write mask per byte of the beat, 1 = masked |
| wr_vld_o | output | 1 | Assembled write word is valid |
| wr_word_o | output | 4*N_W | Assembled write word |
| wr_be_o | output | N_W/2 | Byte enables of the write word |
| wr_col_o | output | COL_W | Column of the first beat of the write group |

## Verification
In a write burst, the word for group g is handed to the core in the same cycle as the first beat of group g+1 is captured. A slip in either the lane index or the output register would mix data from the two groups. Random bursts of length 8 and 16 drive fresh random data and masks on every beat, so each handover lands on a collision cycle. Each word, its byte enables and its group column are compared with values the bench records per beat. A further collision is provoked by holding `start_i` high with different parameters through a whole burst. The burst's length and column sequence must come out undisturbed, which is judged by the same per-beat column checks.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

  typedef enum logic [1:0] {
    LEN4  = 2'd0,
    LEN8  = 2'd1,
    LEN16 = 2'd2,
    LENRS = 2'd3
  } len_code_e;

  // index of the final beat for a length code
  function automatic logic [3:0] last_beat(input logic [1:0] code);
    case (code)
      2'd0:    return 4'd3;
      2'd1:    return 4'd7;
      default: return 4'd15;
    endcase
  endfunction

endpackage

// File: rtl/pbc_burst_seq.sv
module pbc_burst_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic [1:0]       blen_i,
  input  logic             ilv_i,
  input  logic [COL_W-1:0] col_i,
  output logic             core_ph_o,
  output logic             busy_o,
  output logic             wr_mode_o,
  output logic [1:0]       lane_o,
  output logic [COL_W-1:0] beat_col_o
);
  import pbc_pkg::*;

  localparam int CNT_W = 4;

  logic             ph_q, ph_d;
  logic             act_q, act_d;
  logic             wr_q, wr_d;
  logic             ilv_q, ilv_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] lm_q, lm_d;
  logic [COL_W-1:0] col_q, col_d;
  logic             accept, upd_en;
  logic [COL_W-1:0] lm_c, cnt_c, seq_col, ilv_col;

  always_comb begin
    accept = start_i && !act_q && !ph_q && (blen_i != LENRS);
    upd_en = accept || act_q;
    ph_d   = ~ph_q;
    act_d  = act_q;
    cnt_d  = cnt_q;
    lm_d   = lm_q;
    col_d  = col_q;
    wr_d   = wr_q;
    ilv_d  = ilv_q;
    if (accept) begin
      act_d = 1'b1;
      cnt_d = '0;
      lm_d  = last_beat(blen_i);
      col_d = col_i;
      wr_d  = wr_i;
      ilv_d = ilv_i;
    end else if (act_q) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == lm_q) act_d = 1'b0;
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= 1'b0;
      act_q <= 1'b0;
      cnt_q <= '0;
      lm_q  <= '0;
      col_q <= '0;
      wr_q  <= 1'b0;
      ilv_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (upd_en) begin
        act_q <= act_d;
        cnt_q <= cnt_d;
        lm_q  <= lm_d;
        col_q <= col_d;
        wr_q  <= wr_d;
        ilv_q <= ilv_d;
      end
    end
  end

  always_comb begin
    lm_c    = COL_W'(lm_q);
    cnt_c   = COL_W'(cnt_q);
    seq_col = (col_q & ~lm_c) | ((col_q + cnt_c) & lm_c);
    ilv_col = col_q ^ cnt_c;
  end

  assign beat_col_o = ilv_q ? ilv_col : seq_col;
  assign core_ph_o  = ph_q;
  assign busy_o     = act_q;
  assign wr_mode_o  = wr_q;
  assign lane_o     = cnt_q[1:0];

endmodule

// File: rtl/pbc_rd_ser.sv
module pbc_rd_ser #(
  parameter int N_W = 16
) (
  input  logic             clk2x,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             load_i,
  input  logic [4*N_W-1:0] word_i,
  output logic [N_W-1:0]   dq_o,
  output logic             vld_o
);
  localparam int REST_W = 3 * N_W;

  logic [REST_W-1:0] sh_q, sh_d;
  logic [N_W-1:0]    dq_q, dq_d;
  logic              vld_q, vld_d;

  always_comb begin
    sh_d  = sh_q;
    dq_d  = dq_q;
    vld_d = en_i;
    if (en_i && load_i) begin
      dq_d = word_i[N_W-1:0];
      sh_d = word_i[4*N_W-1:N_W];
    end else if (en_i) begin
      dq_d = sh_q[N_W-1:0];
      sh_d = {{N_W{1'b0}}, sh_q[REST_W-1:N_W]};
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      dq_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (en_i) begin
        sh_q <= sh_d;
        dq_q <= dq_d;
      end
    end
  end

  assign dq_o  = dq_q;
  assign vld_o = vld_q;

endmodule

// File: rtl/pbc_wr_des.sv
module pbc_wr_des #(
  parameter int N_W   = 16,
  parameter int COL_W = 10
) (
  input  logic               clk2x,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [1:0]         lane_i,
  input  logic [N_W-1:0]     dq_i,
  input  logic [N_W/8-1:0]   dm_i,
  input  logic [COL_W-1:0]   col_i,
  output logic               vld_o,
  output logic [4*N_W-1:0]   word_o,
  output logic [N_W/2-1:0]   be_o,
  output logic [COL_W-1:0]   col_o
);
  localparam int MB_W   = N_W / 8;
  localparam int WORD_W = 4 * N_W;
  localparam int BE_W   = 4 * MB_W;

  logic [3*N_W-1:0]  ad_q, ad_d;
  logic [3*MB_W-1:0] am_q, am_d;
  logic [COL_W-1:0]  gc_q, gc_d;
  logic              vld_q, vld_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [BE_W-1:0]   be_q, be_d;
  logic [COL_W-1:0]  oc_q, oc_d;
  logic              last_lane, out_en;
  int unsigned       li;

  always_comb begin
    li        = 32'(lane_i);
    last_lane = (lane_i == 2'd3);
    out_en    = en_i && last_lane;
    ad_d      = ad_q;
    am_d      = am_q;
    gc_d      = gc_q;
    word_d    = word_q;
    be_d      = be_q;
    oc_d      = oc_q;
    vld_d     = out_en;
    if (en_i && !last_lane) begin
      ad_d[li*N_W +: N_W]   = dq_i;
      am_d[li*MB_W +: MB_W] = dm_i;
    end
    if (en_i && lane_i == 2'd0) gc_d = col_i;
    if (out_en) begin
      word_d = {dq_i, ad_q};
      be_d   = ~{dm_i, am_q};
      oc_d   = gc_q;
    end
  end

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      ad_q   <= '0;
      am_q   <= '0;
      gc_q   <= '0;
      vld_q  <= 1'b0;
      word_q <= '0;
      be_q   <= '0;
      oc_q   <= '0;
    end else begin
      vld_q <= vld_d;
      if (en_i) begin
        ad_q <= ad_d;
        am_q <= am_d;
        gc_q <= gc_d;
      end
      if (out_en) begin
        word_q <= word_d;
        be_q   <= be_d;
        oc_q   <= oc_d;
      end
    end
  end

  assign vld_o  = vld_q;
  assign word_o = word_q;
  assign be_o   = be_q;
  assign col_o  = oc_q;

endmodule

// File: rtl/prefetch_burst_conv.sv
module prefetch_burst_conv #(
  parameter int N_W   = 16,
  parameter int COL_W = 10
) (
  input  logic               clk2x,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               wr_i,
  input  logic [1:0]         blen_i,
  input  logic               ilv_i,
  input  logic [COL_W-1:0]   col_i,
  output logic               core_ph_o,
  output logic               busy_o,
  output logic [COL_W-1:0]   beat_col_o,
  output logic               rd_req_o,
  input  logic [4*N_W-1:0]   rd_word_i,
  output logic [N_W-1:0]     dq_o,
  output logic               dq_vld_o,
  input  logic [N_W-1:0]     dq_i,
  input  logic [N_W/8-1:0]   dm_i,
  output logic               wr_vld_o,
  output logic [4*N_W-1:0]   wr_word_o,
  output logic [N_W/2-1:0]   wr_be_o,
  output logic [COL_W-1:0]   wr_col_o
);
  logic       wr_mode;
  logic [1:0] lane;
  logic       rd_en, wr_en;

  pbc_burst_seq #(.COL_W(COL_W)) u_seq (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .wr_i      (wr_i),
    .blen_i    (blen_i),
    .ilv_i     (ilv_i),
    .col_i     (col_i),
    .core_ph_o (core_ph_o),
    .busy_o    (busy_o),
    .wr_mode_o (wr_mode),
    .lane_o    (lane),
    .beat_col_o(beat_col_o)
  );

  assign rd_en    = busy_o && !wr_mode;
  assign wr_en    = busy_o && wr_mode;
  assign rd_req_o = rd_en && (lane == 2'd0);

  pbc_rd_ser #(.N_W(N_W)) u_rd (
    .clk2x (clk2x),
    .rst_n (rst_n),
    .en_i  (rd_en),
    .load_i(lane == 2'd0),
    .word_i(rd_word_i),
    .dq_o  (dq_o),
    .vld_o (dq_vld_o)
  );

  pbc_wr_des #(.N_W(N_W), .COL_W(COL_W)) u_wr (
    .clk2x (clk2x),
    .rst_n (rst_n),
    .en_i  (wr_en),
    .lane_i(lane),
    .dq_i  (dq_i),
    .dm_i  (dm_i),
    .col_i (beat_col_o),
    .vld_o (wr_vld_o),
    .word_o(wr_word_o),
    .be_o  (wr_be_o),
    .col_o (wr_col_o)
  );

endmodule

// File: rtl/pbc_chk.sv
module pbc_chk #(
  parameter int COL_W = 10
) (
  input logic             clk2x,
  input logic             rst_n,
  input logic             start_i,
  input logic             core_ph_o,
  input logic             busy_o,
  input logic [COL_W-1:0] beat_col_o,
  input logic             rd_req_o,
  input logic             dq_vld_o,
  input logic             wr_vld_o
);

  p_ph_toggle_r11: assert property (@(posedge clk2x) disable iff (!rst_n)
    1'b1 |=> core_ph_o != $past(core_ph_o));

  p_start_gate_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
    $rose(busy_o) |-> ($past(start_i) && !$past(core_ph_o)));

  p_req_phase_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
    rd_req_o |-> core_ph_o && busy_o);

  p_rd_beat_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
    rd_req_o |=> dq_vld_o);

  p_wr_pulse_r9: assert property (@(posedge clk2x) disable iff (!rst_n)
    wr_vld_o |=> !wr_vld_o);

  p_col_block_r4: assert property (@(posedge clk2x) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |->
      beat_col_o[COL_W-1:4] == $past(beat_col_o[COL_W-1:4]));

endmodule

bind prefetch_burst_conv pbc_chk #(.COL_W(COL_W)) u_pbc_chk (
  .clk2x     (clk2x),
  .rst_n     (rst_n),
  .start_i   (start_i),
  .core_ph_o (core_ph_o),
  .busy_o    (busy_o),
  .beat_col_o(beat_col_o),
  .rd_req_o  (rd_req_o),
  .dq_vld_o  (dq_vld_o),
  .wr_vld_o  (wr_vld_o)
);

// File: tb/prefetch_burst_conv_test.sv
module prefetch_burst_conv_test;
  localparam int CLK_P  = 10;
  localparam int N_W    = 16;
  localparam int COL_W  = 10;
  localparam int WORD_W = 4 * N_W;
  localparam int MB_W   = N_W / 8;
  localparam int BE_W   = 4 * MB_W;

  logic              clk2x = 1'b0;
  logic              rst_n;
  logic              start_i, wr_i, ilv_i;
  logic [1:0]        blen_i;
  logic [COL_W-1:0]  col_i;
  logic              core_ph_o, busy_o, rd_req_o, dq_vld_o, wr_vld_o;
  logic [COL_W-1:0]  beat_col_o, wr_col_o;
  logic [WORD_W-1:0] rd_word_i, wr_word_o;
  logic [N_W-1:0]    dq_o, dq_i;
  logic [MB_W-1:0]   dm_i;
  logic [BE_W-1:0]   wr_be_o;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk2x = ~clk2x;

  prefetch_burst_conv #(.N_W(N_W), .COL_W(COL_W)) uut (
    .clk2x(clk2x), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i),
    .blen_i(blen_i), .ilv_i(ilv_i), .col_i(col_i),
    .core_ph_o(core_ph_o), .busy_o(busy_o), .beat_col_o(beat_col_o),
    .rd_req_o(rd_req_o), .rd_word_i(rd_word_i), .dq_o(dq_o),
    .dq_vld_o(dq_vld_o), .dq_i(dq_i), .dm_i(dm_i), .wr_vld_o(wr_vld_o),
    .wr_word_o(wr_word_o), .wr_be_o(wr_be_o), .wr_col_o(wr_col_o)
  );

  function automatic logic [WORD_W-1:0] mem_word(input logic [COL_W-1:0] c);
    logic [WORD_W-1:0] w;
    for (int l = 0; l < 4; l++)
      w[l*N_W +: N_W] = 16'((int'(c) * 59 + l * 4951) ^ 16'hC0DE);
    return w;
  endfunction

  assign rd_word_i = mem_word(beat_col_o);

  function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] c,
                                              input int bl, input bit ilv,
                                              input int k);
    int off;
    if (ilv) return c ^ COL_W'(k);
    off = int'(c) % bl;
    return COL_W'(int'(c) - off + (off + k) % bl);
  endfunction

  task automatic chk(input string tag, input logic [WORD_W-1:0] act,
                     input logic [WORD_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_burst(input bit wr, input int code, input bit ilv,
                           input logic [COL_W-1:0] col, input bit hold);
    int bl;
    logic [COL_W-1:0]  cols [16];
    logic [WORD_W-1:0] wexp;
    logic [BE_W-1:0]   bexp;
    logic [N_W-1:0]    d;
    logic [MB_W-1:0]   m;
    bl = (code == 0) ? 4 : (code == 1) ? 8 : 16;
    wexp = '0;
    bexp = '0;
    @(negedge clk2x);
    while (busy_o || core_ph_o) @(negedge clk2x);
    start_i = 1'b1; wr_i = wr; blen_i = 2'(code); ilv_i = ilv; col_i = col;
    for (int k = 0; k <= bl; k++) begin
      @(negedge clk2x);
      if (k == 0) chk("R2 busy after start", 64'(busy_o), 64'd1);
      start_i = hold && (k < bl - 1);
      if (hold) begin
        col_i = COL_W'($urandom); ilv_i = ~ilv; wr_i = ~wr; blen_i = 2'd0;
      end
      if (k > 0) begin
        int j;
        j = k - 1;
        if (!wr) begin
          logic [WORD_W-1:0] w;
          w = mem_word(cols[j - j % 4]);
          chk("R7 dq_vld", 64'(dq_vld_o), 64'd1);
          chk("R7 read beat", 64'(dq_o), 64'(w[(j % 4)*N_W +: N_W]));
        end else if (j % 4 == 3) begin
          chk("R9 wr_vld", 64'(wr_vld_o), 64'd1);
          chk("R9 wr_col", 64'(wr_col_o), 64'(cols[j-3]));
          chk("R8 wr_word", wr_word_o, wexp);
          chk("R10 wr_be", 64'(wr_be_o), 64'(bexp));
        end else begin
          chk("R9 wr_vld idle", 64'(wr_vld_o), 64'd0);
        end
      end
      if (k == bl) begin
        chk("R2 burst length", 64'(busy_o), 64'd0);
      end else begin
        cols[k] = exp_col(col, bl, ilv, k);
        chk(ilv ? "R5 interleave col" : "R4 sequential col",
            64'(beat_col_o), 64'(cols[k]));
        if (!wr) begin
          chk("R6 rd_req", 64'(rd_req_o), 64'(k % 4 == 0));
          if (k % 4 == 0) chk("R6 req phase", 64'(core_ph_o), 64'd1);
        end else begin
          d = N_W'($urandom);
          m = MB_W'($urandom);
          dq_i = d; dm_i = m;
          wexp[(k % 4)*N_W +: N_W] = d;
          for (int b = 0; b < MB_W; b++) bexp[(k % 4)*MB_W + b] = ~m[b];
        end
      end
    end
  endtask

  task automatic try_reject(input bit ph, input int code, input string tag);
    @(negedge clk2x);
    while (busy_o || core_ph_o != ph) @(negedge clk2x);
    start_i = 1'b1; wr_i = 1'b0; blen_i = 2'(code); ilv_i = 1'b0; col_i = '0;
    @(negedge clk2x);
    start_i = 1'b0;
    chk(tag, 64'(busy_o), 64'd0);
    @(negedge clk2x);
    chk(tag, 64'(busy_o), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk2x);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic p;
    void'($urandom(32'd4242));
    rst_n = 1'b0; start_i = 1'b0; wr_i = 1'b0; blen_i = 2'd0; ilv_i = 1'b0;
    col_i = '0; dq_i = '0; dm_i = '0;
    repeat (3) @(negedge clk2x);
    chk("R1 busy", 64'(busy_o), 64'd0);
    chk("R1 dq_vld", 64'(dq_vld_o), 64'd0);
    chk("R1 wr_vld", 64'(wr_vld_o), 64'd0);
    chk("R1 phase", 64'(core_ph_o), 64'd0);
    rst_n = 1'b1;
    @(negedge clk2x);
    p = core_ph_o;
    @(negedge clk2x);
    chk("R11 phase toggle", 64'(core_ph_o), 64'(!p));
    @(negedge clk2x);
    chk("R11 phase toggle", 64'(core_ph_o), 64'(p));

    // directed corners
    run_burst(1'b0, 2, 1'b0, 10'd13, 1'b0);   // R4 wrap inside 16-block
    run_burst(1'b0, 0, 1'b0, 10'd6, 1'b0);    // R4 wrap inside 4-block
    run_burst(1'b0, 1, 1'b1, 10'd5, 1'b0);    // R5
    run_burst(1'b1, 0, 1'b1, 10'd3, 1'b0);    // R5 write
    run_burst(1'b1, 2, 1'b0, 10'd1023, 1'b0); // R8 R9 top column
    run_burst(1'b0, 1, 1'b0, 10'd9, 1'b1);    // R2 start held during burst
    run_burst(1'b1, 1, 1'b1, 10'd2, 1'b1);    // R2 held start, write
    try_reject(1'b1, 0, "R2 start on odd phase ignored");
    try_reject(1'b0, 3, "R3 reserved length ignored");

    // random bursts
    for (int i = 0; i < 40; i++)
      run_burst(1'($urandom), int'($urandom % 3), 1'($urandom),
                COL_W'($urandom), 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule